// File: doc/BRIEF.md
# Program Memory Password Lock

This block decides, after every reset, whether program memory holds a usable access password. It then holds a lock flag that gates in-system programming, in-application programming and in-circuit debug access. Right after reset it walks the 32-byte password region as sixteen 16-bit words through a synchronous memory read port with one cycle of read latency. It keeps a copy of every word, and it tracks whether the whole region is blank in either direction.

A region made entirely of 0000h words or entirely of FFFFh words counts as no password. Any other content counts as a real password and sets the lock once the scan ends. A programming interface can later offer a 16-word candidate. If every word matches the stored copy, the lock clears. If any word differs, the block reports a failure and the lock is left as it was. When the lock is already clear, because no password exists or a match already happened, any attempt is reported as a success.

Top module: `pwd_lock`

## Requirements
- R1: From the first clock after reset release, the block reads word addresses 0010h up to 001Fh in ascending order, one address per cycle. `memRdEn` is high for exactly those 16 cycles, and `memAddr` holds 0010h while reset is being released.
- R2: `scanDone` rises on the 17th rising clock edge after reset release. It then stays high until the next reset, and no further reads are issued.
- R3: When `scanDone` rises, `lockOut` becomes 1 unless the 16 words are all 0000h or all FFFFh. A region that mixes 0000h and FFFFh words counts as valid and sets the lock.
- R4: `lockOut` is 0 during reset and throughout the scan.
- R5: With the lock set, a request presents candidate word i in `matchWords[16*i+15:16*i]`, compared with the word read from address 0010h+i. If all 16 words are equal, `matchOk` pulses high one cycle after the request, and `lockOut` falls on the same edge.
- R6: With the lock set, if any one candidate word differs from its stored word, `matchFail` pulses high one cycle after the request, and `lockOut` stays 1.
- R7: With the lock clear, every request gets `matchOk` one cycle later, whatever the candidate.
- R8: A `matchReq` raised before `scanDone` is high gets no response: neither pulse appears, and the lock is unaffected.
- R9: `matchOk` and `matchFail` are never high together. Each request cycle produces exactly one of them on the next cycle.
- R10: Once `scanDone` is high, `lockOut` never rises again until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| memRdEn | output | 1 | Read strobe to program memory |
| memAddr | output | ADDR_W (16) | Word address of the read |
| memRdData | input | WORD_W (16) | Read data, valid one cycle after the strobe |
| matchReq | input | 1 | One-cycle match attempt request |
| matchWords | input | NUM_WORDS*WORD_W (256) | Candidate password, word i in bits [16i+15:16i] |
| lockOut | output | 1 | Lock flag: 1 means protected access is refused |
| scanDone | output | 1 | Password region has been read and evaluated |
| matchOk | output | 1 | One-cycle pulse: attempt accepted |
| matchFail | output | 1 | One-cycle pulse: attempt rejected |

## Verification
The hardest situation to reach from the ports is an attempt that differs from the stored password in one bit of one word, at either end of the region. Only this case shows whether every word takes part in the compare. The bench loads a memory model with a non-trivial password, then offers candidates with a single bit flipped in the first word and in the last word, and expects a rejection with the lock still held. The blank-region corners are reached by reloading the model with all-zero, all-ones and alternating 0000h/FFFFh contents before each reset. A request is also raised in the middle of the scan, to show that it is ignored.

// File: rtl/pwd_lock_pkg.sv
package pwd_lock_pkg;
  typedef struct packed {
    logic capture;   // read data on memRdData belongs to the region
    logic lastWord;  // this capture is the final word of the region
    logic tryMatch;  // evaluate the candidate this cycle
  } pwStrobe_t;
endpackage

// File: rtl/pwd_lock_ctrl.sv
module pwd_lock_ctrl
  import pwd_lock_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 16,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned BASE_ADDR = 16'h0010,
  localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              matchReq,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  output pwStrobe_t         strobe,
  output logic [IDX_W-1:0]  capIdx,
  output logic              scanDone
);
  localparam int unsigned CNT_W = IDX_W + 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

  logic [CNT_W-1:0] issueCnt;
  logic             issuing;
  logic             rdPend;
  logic [IDX_W-1:0] rdIdx;
  logic             doneQ;

  // NUM_WORDS is a power of two: the top count bit marks the end of issue
  assign issuing = ~issueCnt[IDX_W];
  assign memRdEn = issuing;
  assign memAddr = ADDR_W'(BASE_ADDR) + ADDR_W'(issueCnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issueCnt <= '0;
      rdPend   <= 1'b0;
      rdIdx    <= '0;
      doneQ    <= 1'b0;
    end else begin
      if (issuing) issueCnt <= issueCnt + 1'b1;
      rdPend <= issuing;
      rdIdx  <= issueCnt[IDX_W-1:0];
      if (rdPend && (rdIdx == LAST_IDX)) doneQ <= 1'b1;
    end
  end

  always_comb begin
    strobe.capture  = rdPend;
    strobe.lastWord = rdPend && (rdIdx == LAST_IDX);
    strobe.tryMatch = doneQ && matchReq;
  end

  assign capIdx   = rdIdx;
  assign scanDone = doneQ;
endmodule

// File: rtl/pwd_lock_dp.sv
module pwd_lock_dp
  import pwd_lock_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 16,
  parameter int unsigned WORD_W    = 16,
  localparam int unsigned IDX_W    = $clog2(NUM_WORDS),
  localparam int unsigned FLAT_W   = NUM_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pwStrobe_t         strobe,
  input  logic [IDX_W-1:0]  capIdx,
  input  logic [WORD_W-1:0] memRdData,
  input  logic [FLAT_W-1:0] matchWords,
  output logic              lockOut,
  output logic              matchOk,
  output logic              matchFail
);
  logic [FLAT_W-1:0] storedFlat;
  logic              allZero, allOnes;
  logic              wordZero, wordOnes;
  logic              candEq;
  logic              lockQ, okQ, failQ;

  assign wordZero = (memRdData == '0);
  assign wordOnes = (memRdData == '1);
  assign candEq   = (storedFlat == matchWords);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      storedFlat <= '0;
      allZero    <= 1'b1;
      allOnes    <= 1'b1;
      lockQ      <= 1'b0;
      okQ        <= 1'b0;
      failQ      <= 1'b0;
    end else begin
      okQ   <= 1'b0;
      failQ <= 1'b0;
      if (strobe.capture) begin
        storedFlat[capIdx*WORD_W +: WORD_W] <= memRdData;
        allZero <= allZero & wordZero;
        allOnes <= allOnes & wordOnes;
      end
      if (strobe.lastWord)
        lockQ <= ~((allZero & wordZero) | (allOnes & wordOnes));
      if (strobe.tryMatch) begin
        if (!lockQ || candEq) begin
          okQ   <= 1'b1;
          lockQ <= 1'b0;
        end else begin
          failQ <= 1'b1;
        end
      end
    end
  end

  assign lockOut   = lockQ;
  assign matchOk   = okQ;
  assign matchFail = failQ;
endmodule

// File: rtl/pwd_lock.sv
module pwd_lock
  import pwd_lock_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 16,
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned BASE_ADDR = 16'h0010
) (
  input  logic                        clk,
  input  logic                        rst_n,
  output logic                        memRdEn,
  output logic [ADDR_W-1:0]           memAddr,
  input  logic [WORD_W-1:0]           memRdData,
  input  logic                        matchReq,
  input  logic [NUM_WORDS*WORD_W-1:0] matchWords,
  output logic                        lockOut,
  output logic                        scanDone,
  output logic                        matchOk,
  output logic                        matchFail
);
  localparam int unsigned IDX_W = $clog2(NUM_WORDS);

  pwStrobe_t        strobe;
  logic [IDX_W-1:0] capIdx;

  pwd_lock_ctrl #(
    .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .matchReq(matchReq),
    .memRdEn(memRdEn), .memAddr(memAddr),
    .strobe(strobe), .capIdx(capIdx), .scanDone(scanDone)
  );

  pwd_lock_dp #(
    .NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .capIdx(capIdx),
    .memRdData(memRdData), .matchWords(matchWords),
    .lockOut(lockOut), .matchOk(matchOk), .matchFail(matchFail)
  );
endmodule

// File: rtl/pwd_lock_chk.sv
module pwd_lock_chk #(
  parameter int unsigned NUM_WORDS = 16,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned BASE_ADDR = 16'h0010
) (
  input logic              clk,
  input logic              rst_n,
  input logic              memRdEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic              matchReq,
  input logic              lockOut,
  input logic              scanDone,
  input logic              matchOk,
  input logic              matchFail
);
  localparam int unsigned RC_W = $clog2(NUM_WORDS) + 2;
  logic [RC_W-1:0] rdCount;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdCount <= '0;
    else if (memRdEn) rdCount <= rdCount + 1'b1;
  end

  assert_addr_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    memRdEn |-> (memAddr >= ADDR_W'(BASE_ADDR)) && (memAddr < ADDR_W'(BASE_ADDR + NUM_WORDS)));

  assert_read_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    scanDone |-> (rdCount == RC_W'(NUM_WORDS)) && !memRdEn);

  assert_done_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    scanDone |=> scanDone);

  assert_lock_clear_scan_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !scanDone |-> !lockOut);

  assert_fall_needs_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lockOut) |-> matchOk);

  assert_fail_keeps_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    matchFail |-> lockOut && $stable(lockOut));

  assert_early_req_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !scanDone |=> !matchOk && !matchFail);

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(matchOk && matchFail));

  assert_one_reply_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (scanDone && matchReq) |=> (matchOk || matchFail));

  assert_no_relock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lockOut) |-> $rose(scanDone));
endmodule

bind pwd_lock pwd_lock_chk #(
  .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .memRdEn(memRdEn), .memAddr(memAddr),
  .matchReq(matchReq), .lockOut(lockOut), .scanDone(scanDone),
  .matchOk(matchOk), .matchFail(matchFail)
);

// File: tb/pwd_lock_bench.sv
module pwd_lock_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int NW = 16;
  localparam int WW = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            memRdEn;
  logic [15:0]     memAddr;
  logic [WW-1:0]   memRdData;
  logic            matchReq = 1'b0;
  logic [NW*WW-1:0] matchWords = '0;
  logic            lockOut, scanDone, matchOk, matchFail;

  logic [15:0] mem [64];
  logic [NW*WW-1:0] pwd;
  int testCount = 0;
  int failCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (memRdEn) memRdData <= mem[memAddr[5:0]];

  pwd_lock u_pwd_lock (
    .clk(clk), .rst_n(rst_n), .memRdEn(memRdEn), .memAddr(memAddr),
    .memRdData(memRdData), .matchReq(matchReq), .matchWords(matchWords),
    .lockOut(lockOut), .scanDone(scanDone), .matchOk(matchOk), .matchFail(matchFail)
  );

  task automatic check(input bit cond, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (!cond) begin
      failCount++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // mode 0: all 0000h, 1: all FFFFh, 2: alternating 0000h/FFFFh, 3: ordinary password
  task automatic loadRegion(input int mode);
    for (int a = 0; a < 64; a++) mem[a] = 16'hA5A5;
    for (int i = 0; i < NW; i++) begin
      case (mode)
        0: mem[16+i] = 16'h0000;
        1: mem[16+i] = 16'hFFFF;
        2: mem[16+i] = (i % 2 == 0) ? 16'h0000 : 16'hFFFF;
        default: mem[16+i] = 16'h1357 + 16'(i * 16'h0931);
      endcase
      pwd[i*WW +: WW] = mem[16+i];
    end
  endtask

  // reset, follow the scan cycle by cycle, probe an early request
  task automatic resetAndScan(input int mode, input bit expLock);
    @(negedge clk);
    rst_n = 1'b0;
    loadRegion(mode);
    @(negedge clk);
    check(!lockOut && !scanDone && !matchOk && !matchFail, "R4", "reset outputs",
          {lockOut, scanDone, matchOk, matchFail}, 0);
    rst_n = 1'b1;
    for (int k = 0; k <= 17; k++) begin
      check(memRdEn == (k < 16), "R1", "read enable", memRdEn, (k < 16));
      if (k < 16) check(memAddr == 16'(16 + k), "R1", "read address", memAddr, 16 + k);
      check(scanDone == (k >= 17), "R2", "done timing", scanDone, (k >= 17));
      if (k < 17) check(!lockOut, "R4", "lock during scan", lockOut, 0);
      if (k == 4) begin matchReq = 1'b1; matchWords = pwd; end
      if (k == 5) begin
        matchReq = 1'b0;
        check(!matchOk && !matchFail, "R8", "early request reply",
              {matchOk, matchFail}, 0);
      end
      if (k < 17) begin @(posedge clk); @(negedge clk); end
    end
    check(lockOut == expLock, "R3", "lock after scan", lockOut, expLock);
    repeat (3) @(negedge clk);
    check(scanDone && !memRdEn, "R2", "done sticky, reads stopped", {scanDone, memRdEn}, 2);
  endtask

  task automatic tryMatch(input logic [NW*WW-1:0] cand, input bit expOk,
                          input bit expLock, input string req);
    @(negedge clk);
    matchReq = 1'b1;
    matchWords = cand;
    @(negedge clk);
    matchReq = 1'b0;
    check(matchOk == expOk && matchFail == !expOk, req, "reply pulses",
          {matchOk, matchFail}, {expOk, !expOk});
    check(!(matchOk && matchFail), "R9", "exclusive replies", {matchOk, matchFail}, {expOk, !expOk});
    check(lockOut == expLock, req, "lock after attempt", lockOut, expLock);
    @(negedge clk);
    check(!matchOk && !matchFail, "R9", "single pulse", {matchOk, matchFail}, 0);
    check(lockOut == expLock, "R10", "lock holds", lockOut, expLock);
  endtask

  task automatic testValidPassword();
    logic [NW*WW-1:0] bad;
    resetAndScan(3, 1'b1);
    bad = pwd; bad[0] = ~bad[0];
    tryMatch(bad, 1'b0, 1'b1, "R6");
    bad = pwd; bad[NW*WW-1] = ~bad[NW*WW-1];
    tryMatch(bad, 1'b0, 1'b1, "R6");
    tryMatch(pwd, 1'b1, 1'b0, "R5");
    tryMatch(~pwd, 1'b1, 1'b0, "R7");
  endtask

  task automatic testBlankZero();
    resetAndScan(0, 1'b0);
    tryMatch({NW{16'hBEEF}}, 1'b1, 1'b0, "R7");
  endtask

  task automatic testBlankOnes();
    resetAndScan(1, 1'b0);
    tryMatch('0, 1'b1, 1'b0, "R7");
  endtask

  task automatic testMixedBlankValues();
    logic [NW*WW-1:0] bad;
    resetAndScan(2, 1'b1);
    bad = pwd; bad[WW*7] = ~bad[WW*7];
    tryMatch(bad, 1'b0, 1'b1, "R6");
    tryMatch(pwd, 1'b1, 1'b0, "R5");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    testValidPassword();
    testBlankZero();
    testBlankOnes();
    testMixedBlankValues();
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule